// File: doc/BRIEF.md
# MESI Cache Line Controller

This block keeps one cached line for one processor in a snooping multiprocessor system. The line holds a coherence state and one data word. Two independent agents work on the line. The processor agent serves loads and stores. When the line state does not allow an access, it asks the memory controller for data, for store permission, or for both. The snoop agent answers queries and invalidations that the memory controller starts on its own.

Neither agent reads or changes the line until it owns a shared lock. An agent takes the lock with a test-and-set, keeps it for its whole transaction, and then releases it. A snoop that arrives in the middle of a processor transaction therefore waits until that transaction ends. If both agents ask for a free lock in the same cycle, the snoop agent gets it, so that the memory controller can make progress.

Every request channel uses a valid/ready handshake and holds one message at a time.

Processor agent states, in order of use:
- `CP_IDLE` accepts a request.
- `CP_LOCK` waits for the lock, then takes one of two paths. A hit goes to `CP_RESP`. A miss goes to `CP_MREQ`.
- `CP_MREQ` offers the request to the memory controller. Once it is accepted the agent goes to `CP_MWAIT`.
- `CP_MWAIT` waits for the memory response. When it arrives, the agent goes to `CP_RESP`.
- `CP_RESP` answers the processor, releases the lock and returns to `CP_IDLE`.

Snoop agent states:
- `SN_IDLE` accepts a snoop and goes to `SN_LOCK`.
- `SN_LOCK` waits for the lock. Once it holds the lock it goes to `SN_RESP`.
- `SN_RESP` answers the memory controller, updates the line state, releases the lock and returns to `SN_IDLE`.

The lock owner takes three values: `OWN_NONE`, `OWN_CPU` and `OWN_SNP`. The owner moves from `OWN_NONE` to an agent when that agent requests the lock. It moves back to `OWN_NONE` when the holder releases the lock.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid. Both request channels are ready, and no response or memory request is driven. The first load therefore produces a memory request.
- R2: A load to an Invalid line issues a memory request with `mem_req_kind` = 0 (read). The processor gets no response until the memory response arrives. The line then becomes Exclusive if `mem_rsp_excl` = 1 and Shared otherwise, and the load returns `mem_rsp_data`.
- R3: A load to a Shared, Exclusive or Modified line makes no memory request. It returns the line data with `cpu_rsp_valid` high at the third falling edge after the accepting clock edge.
- R4: A store to a Modified line makes no memory request and answers with the same latency as R3. It writes `cpu_req_wdata`, and a later load returns that value.
- R5: A store to a Shared or Exclusive line issues `mem_req_kind` = 1 (permission only). After the response the line is Modified and holds the store data.
- R6: A store to an Invalid line issues `mem_req_kind` = 2 (data plus permission). After the response the line is Modified and holds the store data, not the fetched data.
- R7: The line enters Modified only in the cycle after a memory response. A store response is only given while the line is Modified. A processor response is never given from an Invalid line.
- R8: A read snoop (`snp_kind` = 0) reports `snp_rsp_dirty` = 1 with the line data when the line is Modified. It moves a Modified or Exclusive line to Shared, and leaves a Shared or Invalid line unchanged.
- R9: An ownership snoop (`snp_kind` = 1) reports dirty data when the line is Modified, and moves the line to Invalid in every case.
- R10: At most one agent holds the line. A processor request and a snoop accepted in the same cycle are served snoop first. Processor and snoop responses never occur in the same cycle.
- R11: A snoop accepted while the processor agent waits for memory is not answered until after the processor response.
- R12: Each channel holds one message: `cpu_req_ready` and `snp_ready` are low while their agent is busy. A pending memory request keeps its kind until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Processor response, one cycle |
| cpu_rsp_rdata | output | DATA_W | Line data after the access |
| mem_req_valid | output | 1 | Request to the memory controller |
| mem_req_ready | input | 1 | Memory controller accepts request |
| mem_req_kind | output | 2 | 0 read, 1 permission, 2 read with permission |
| mem_rsp_valid | input | 1 | Memory response, one cycle |
| mem_rsp_excl | input | 1 | Read fill may be held Exclusive |
| mem_rsp_data | input | DATA_W | Fill data |
| snp_valid | input | 1 | Snoop request valid |
| snp_ready | output | 1 | Snoop accepted |
| snp_kind | input | 1 | 0 read snoop, 1 ownership snoop |
| snp_rsp_valid | output | 1 | Snoop answer, one cycle |
| snp_rsp_dirty | output | 1 | Line was Modified; data attached |
| snp_rsp_data | output | DATA_W | Line data |

## Verification
Lock hand-off is registered, so each result is due a fixed number of cycles after its stimulus:
- A hit answers at the third falling edge after the accepting edge.
- A miss raises `mem_req_valid` at that same third falling edge.
- A miss answers at the falling edge after the edge that takes `mem_rsp_valid`.
- A snoop on a free line answers at the third falling edge after its acceptance.

The bench drives inputs and samples outputs only at falling edges. It counts those edges from the accepting edge and checks the hit and store-in-Modified latencies exactly. For races it records the falling edge at which each response first appears. Line states are not visible at the ports, so the bench infers them from which memory request, if any, the next access produces.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        MQ_READ     = 2'd0,
        MQ_UPGRADE  = 2'd1,
        MQ_READ_OWN = 2'd2,
        MQ_RSVD     = 2'd3
    } mem_req_kind_t;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_SNP  = 2'd2,
        OWN_BAD  = 2'd3
    } lock_owner_t;

endpackage

// File: rtl/line_lock.sv
module line_lock
    import mesi_line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic snp_req,
    input  logic cpu_rel,
    input  logic snp_rel,
    output logic cpu_gnt,
    output logic snp_gnt
);

    lock_owner_t owner_q, owner_d;

    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
    end

    always_comb begin
        owner_d = owner_q;
        unique case (owner_q)
            OWN_NONE: begin
                if (snp_req)      owner_d = OWN_SNP;
                else if (cpu_req) owner_d = OWN_CPU;
            end
            OWN_CPU:  if (cpu_rel) owner_d = OWN_NONE;
            OWN_SNP:  if (snp_rel) owner_d = OWN_NONE;
            default:  owner_d = OWN_NONE;
        endcase
    end

    always_comb begin
        cpu_gnt = (owner_q == OWN_CPU);
        snp_gnt = (owner_q == OWN_SNP);
    end

    // R10: the snoop agent wins a tie for a free lock
    a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_NONE && snp_req && cpu_req) |=> (snp_gnt && !cpu_gnt));

endmodule

// File: rtl/line_store.sv
module line_store
    import mesi_line_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  line_state_t       cpu_state,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              snp_we,
    input  line_state_t       snp_state,
    output line_state_t       state_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_INV;
            data_q  <= '0;
        end else if (cpu_we) begin
            state_q <= cpu_state;
            data_q  <= cpu_data;
        end else if (snp_we) begin
            state_q <= snp_state;
        end
    end

    // R10: only the lock holder writes, so two writers never meet
    a_r10_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && snp_we));

endmodule

// File: rtl/cpu_path.sv
module cpu_path
    import mesi_line_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_kind,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_excl,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              lock_req,
    input  logic              lock_gnt,
    output logic              lock_rel,
    input  line_state_t       line_state,
    input  logic [DATA_W-1:0] line_data,
    output logic              wr_en,
    output line_state_t       wr_state,
    output logic [DATA_W-1:0] wr_data
);

    typedef enum logic [2:0] {
        CP_IDLE  = 3'd0,
        CP_LOCK  = 3'd1,
        CP_MREQ  = 3'd2,
        CP_MWAIT = 3'd3,
        CP_RESP  = 3'd4
    } cp_state_t;

    cp_state_t         st_q, st_d;
    logic              op_wr_q;
    logic [DATA_W-1:0] op_wd_q;
    mem_req_kind_t     kind_q, kind_d;
    logic              hit;

    always_comb begin
        if (op_wr_q) hit = (line_state == LN_MOD);
        else         hit = (line_state != LN_INV);
    end

    always_comb begin
        if (!op_wr_q)                  kind_d = MQ_READ;
        else if (line_state == LN_INV) kind_d = MQ_READ_OWN;
        else                           kind_d = MQ_UPGRADE;
    end

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CP_IDLE;
            op_wr_q <= 1'b0;
            op_wd_q <= '0;
            kind_q  <= MQ_READ;
        end else begin
            st_q <= st_d;
            if (st_q == CP_IDLE && req_valid) begin
                op_wr_q <= req_write;
                op_wd_q <= req_wdata;
            end
            if (st_q == CP_LOCK && lock_gnt && !hit) kind_q <= kind_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CP_IDLE:  if (req_valid) st_d = CP_LOCK;
            CP_LOCK:  if (lock_gnt) st_d = hit ? CP_RESP : CP_MREQ;
            CP_MREQ:  if (mem_req_ready) st_d = CP_MWAIT;
            CP_MWAIT: if (mem_rsp_valid) st_d = CP_RESP;
            CP_RESP:  st_d = CP_IDLE;
            default:  st_d = CP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_rdata     = line_data;
        mem_req_valid = 1'b0;
        mem_req_kind  = kind_q;
        lock_req      = 1'b0;
        lock_rel      = 1'b0;
        wr_en         = 1'b0;
        wr_state      = LN_MOD;
        wr_data       = op_wd_q;
        unique case (st_q)
            CP_IDLE:  req_ready = 1'b1;
            CP_LOCK: begin
                lock_req = 1'b1;
                wr_en    = lock_gnt && hit && op_wr_q;
            end
            CP_MREQ:  mem_req_valid = 1'b1;
            CP_MWAIT: begin
                wr_en = mem_rsp_valid;
                if (!op_wr_q) begin
                    wr_state = mem_rsp_excl ? LN_EXC : LN_SHR;
                    wr_data  = mem_rsp_data;
                end
            end
            CP_RESP: begin
                rsp_valid = 1'b1;
                lock_rel  = 1'b1;
            end
            default: ;
        endcase
    end

    // R7: no response is ever served from an Invalid line
    a_r7_no_data_from_inv: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (line_state != LN_INV));

    // R7: stores complete only on a Modified line
    a_r7_store_needs_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_wr_q) |-> (line_state == LN_MOD));

    // R12: a waiting memory request holds its kind
    a_r12_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_kind)));

endmodule

// File: rtl/snoop_path.sv
module snoop_path
    import mesi_line_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    output logic              snp_ready,
    input  logic              snp_kind,
    output logic              rsp_valid,
    output logic              rsp_dirty,
    output logic [DATA_W-1:0] rsp_data,
    output logic              lock_req,
    input  logic              lock_gnt,
    output logic              lock_rel,
    input  line_state_t       line_state,
    input  logic [DATA_W-1:0] line_data,
    output logic              st_we,
    output line_state_t       st_new
);

    typedef enum logic [1:0] {
        SN_IDLE = 2'd0,
        SN_LOCK = 2'd1,
        SN_RESP = 2'd2
    } sn_state_t;

    sn_state_t st_q, st_d;
    logic      own_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SN_IDLE;
            own_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == SN_IDLE && snp_valid) own_q <= snp_kind;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SN_IDLE: if (snp_valid) st_d = SN_LOCK;
            SN_LOCK: if (lock_gnt) st_d = SN_RESP;
            SN_RESP: st_d = SN_IDLE;
            default: st_d = SN_IDLE;
        endcase
    end

    always_comb begin
        snp_ready = (st_q == SN_IDLE);
        lock_req  = (st_q == SN_LOCK);
        rsp_valid = 1'b0;
        rsp_dirty = 1'b0;
        rsp_data  = line_data;
        lock_rel  = 1'b0;
        st_we     = 1'b0;
        st_new    = line_state;
        if (st_q == SN_RESP) begin
            rsp_valid = 1'b1;
            rsp_dirty = (line_state == LN_MOD);
            lock_rel  = 1'b1;
            st_we     = 1'b1;
            if (own_q)                     st_new = LN_INV;
            else if (line_state != LN_INV) st_new = LN_SHR;
        end
    end

    // R9: an ownership snoop leaves the line Invalid
    a_r9_own_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && own_q) |=> (line_state == LN_INV));

    // R8: a read snoop on a valid line leaves it Shared
    a_r8_read_shares: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !own_q && line_state != LN_INV) |=> (line_state == LN_SHR));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_line_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_kind,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_excl,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              snp_valid,
    output logic              snp_ready,
    input  logic              snp_kind,
    output logic              snp_rsp_valid,
    output logic              snp_rsp_dirty,
    output logic [DATA_W-1:0] snp_rsp_data
);

    logic              cpu_lreq, cpu_lgnt, cpu_lrel;
    logic              snp_lreq, snp_lgnt, snp_lrel;
    logic              cpu_we, snp_we;
    line_state_t       cpu_wst, snp_wst, line_st;
    logic [DATA_W-1:0] cpu_wd, line_dat;

    line_lock u_lock (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_lreq), .snp_req(snp_lreq),
        .cpu_rel(cpu_lrel), .snp_rel(snp_lrel),
        .cpu_gnt(cpu_lgnt), .snp_gnt(snp_lgnt)
    );

    line_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_we), .cpu_state(cpu_wst), .cpu_data(cpu_wd),
        .snp_we(snp_we), .snp_state(snp_wst),
        .state_q(line_st), .data_q(line_dat)
    );

    cpu_path #(.DATA_W(DATA_W)) u_cpu (
        .clk(clk), .rst_n(rst_n),
        .req_valid(cpu_req_valid), .req_ready(cpu_req_ready),
        .req_write(cpu_req_write), .req_wdata(cpu_req_wdata),
        .rsp_valid(cpu_rsp_valid), .rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_kind(mem_req_kind), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_excl(mem_rsp_excl), .mem_rsp_data(mem_rsp_data),
        .lock_req(cpu_lreq), .lock_gnt(cpu_lgnt), .lock_rel(cpu_lrel),
        .line_state(line_st), .line_data(line_dat),
        .wr_en(cpu_we), .wr_state(cpu_wst), .wr_data(cpu_wd)
    );

    snoop_path #(.DATA_W(DATA_W)) u_snp (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_kind(snp_kind),
        .rsp_valid(snp_rsp_valid), .rsp_dirty(snp_rsp_dirty), .rsp_data(snp_rsp_data),
        .lock_req(snp_lreq), .lock_gnt(snp_lgnt), .lock_rel(snp_lrel),
        .line_state(line_st), .line_data(line_dat),
        .st_we(snp_we), .st_new(snp_wst)
    );

    // R7: Modified is entered only right after a memory grant
    a_r7_mod_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st == LN_MOD && $past(line_st) != LN_MOD) |-> $past(mem_rsp_valid));

    // R10: the two agents never answer in the same cycle
    a_r10_rsp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rsp_valid && snp_rsp_valid));

endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready, cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_rdata;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [1:0]    mem_req_kind;
    logic          mem_rsp_valid = 1'b0, mem_rsp_excl = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          snp_valid = 1'b0, snp_kind = 1'b0;
    logic          snp_ready, snp_rsp_valid, snp_rsp_dirty;
    logic [DW-1:0] snp_rsp_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.DATA_W(DW)) i_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_kind(mem_req_kind), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_excl(mem_rsp_excl), .mem_rsp_data(mem_rsp_data),
        .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_kind(snp_kind),
        .snp_rsp_valid(snp_rsp_valid), .snp_rsp_dirty(snp_rsp_dirty),
        .snp_rsp_data(snp_rsp_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one processor access; answers a memory request if one appears
    task automatic do_cpu(input bit wr, input logic [DW-1:0] wd, input bit exp_mem,
                          input logic [1:0] exp_kind, input logic [DW-1:0] fill,
                          input bit excl, input logic [DW-1:0] exp_rd, input string req);
        int n;
        bit saw_mem, got;
        logic [1:0] kind;
        logic [DW-1:0] rd;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        n = 1; saw_mem = 0; got = 0; kind = 2'd3; rd = '0;
        while (!got && n < 50) begin
            if (mem_req_valid && !saw_mem) begin
                saw_mem = 1; kind = mem_req_kind;
                @(negedge clk); n++;
                mem_rsp_valid = 1'b1; mem_rsp_data = fill; mem_rsp_excl = excl;
                @(negedge clk); n++;
                mem_rsp_valid = 1'b0;
                continue;
            end
            if (cpu_rsp_valid) begin
                got = 1; rd = cpu_rsp_rdata;
            end else begin
                @(negedge clk); n++;
            end
        end
        check(got, req, "cpu response seen", 64'(got), 64'd1);
        check(saw_mem == exp_mem, req, "memory request made", 64'(saw_mem), 64'(exp_mem));
        if (exp_mem) check(kind == exp_kind, req, "memory request kind", 64'(kind), 64'(exp_kind));
        else check(n == 3, req, "hit latency in falling edges", 64'(n), 64'd3);
        check(rd == exp_rd, req, "cpu read data", 64'(rd), 64'(exp_rd));
    endtask

    task automatic do_snoop(input bit own, input bit exp_dirty,
                            input logic [DW-1:0] exp_data, input string req);
        int n;
        bit got, dirty;
        logic [DW-1:0] d;
        @(negedge clk);
        snp_valid = 1'b1; snp_kind = own;
        while (!snp_ready) @(negedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        n = 1; got = 0; dirty = 0; d = '0;
        while (!got && n < 30) begin
            if (snp_rsp_valid) begin
                got = 1; dirty = snp_rsp_dirty; d = snp_rsp_data;
            end else begin
                @(negedge clk); n++;
            end
        end
        check(got && n == 3, req, "snoop answer at third falling edge", 64'(n), 64'd3);
        check(dirty == exp_dirty, req, "snoop dirty flag", 64'(dirty), 64'(exp_dirty));
        if (exp_dirty) check(d == exp_data, req, "snoop dirty data", 64'(d), 64'(exp_data));
    endtask

    task automatic t_reset;
        check(cpu_req_ready && snp_ready, "R1", "ready after reset",
              64'({cpu_req_ready, snp_ready}), 64'd3);
        check(!cpu_rsp_valid && !mem_req_valid && !snp_rsp_valid, "R1", "idle outputs",
              64'({cpu_rsp_valid, mem_req_valid, snp_rsp_valid}), 64'd0);
        // R1 R2: first load misses, fill not exclusive -> Shared
        do_cpu(0, '0, 1, 2'd0, 32'hA0A0_0001, 0, 32'hA0A0_0001, "R2");
    endtask

    task automatic t_hits_and_stores;
        do_cpu(0, '0, 0, 2'd0, '0, 0, 32'hA0A0_0001, "R3");
        do_snoop(0, 0, '0, "R8");   // read snoop on Shared: clean
        do_cpu(1, 32'hB0B0_0002, 1, 2'd1, 32'hDEAD, 0, 32'hB0B0_0002, "R5");
        do_cpu(1, 32'hC0C0_0003, 0, 2'd0, '0, 0, 32'hC0C0_0003, "R4");
        do_cpu(0, '0, 0, 2'd0, '0, 0, 32'hC0C0_0003, "R4");
    endtask

    task automatic t_snoops;
        do_snoop(0, 1, 32'hC0C0_0003, "R8");
        do_cpu(0, '0, 0, 2'd0, '0, 0, 32'hC0C0_0003, "R8");  // still valid
        do_cpu(1, 32'hD0D0_0004, 1, 2'd1, 32'hDEAD, 0, 32'hD0D0_0004, "R8"); // was Shared
        do_snoop(1, 1, 32'hD0D0_0004, "R9");
        do_cpu(0, '0, 1, 2'd0, 32'hE0E0_0005, 1, 32'hE0E0_0005, "R9"); // invalid -> miss, Exclusive
        do_cpu(1, 32'hF0F0_0006, 1, 2'd1, 32'hDEAD, 0, 32'hF0F0_0006, "R5"); // Exclusive store
        do_snoop(1, 1, 32'hF0F0_0006, "R9");
        do_cpu(1, 32'h1111_0007, 1, 2'd2, 32'hBAD0_BAD0, 0, 32'h1111_0007, "R6");
        do_cpu(0, '0, 0, 2'd0, '0, 0, 32'h1111_0007, "R6");
    endtask

    task automatic t_tie;
        int cpu_at, snp_at;
        bit mem_seen, dirty;
        logic [DW-1:0] cd, sd;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0;
        snp_valid = 1'b1; snp_kind = 1'b0;
        @(negedge clk);
        cpu_req_valid = 1'b0; snp_valid = 1'b0;
        cpu_at = 0; snp_at = 0; mem_seen = 0; dirty = 0; cd = '0; sd = '0;
        for (int n = 1; n < 20; n++) begin
            if (mem_req_valid) mem_seen = 1;
            if (cpu_rsp_valid && cpu_at == 0) begin cpu_at = n; cd = cpu_rsp_rdata; end
            if (snp_rsp_valid && snp_at == 0) begin
                snp_at = n; dirty = snp_rsp_dirty; sd = snp_rsp_data;
            end
            @(negedge clk);
        end
        check(snp_at != 0 && cpu_at > snp_at, "R10", "snoop served before cpu",
              64'({cpu_at[15:0], snp_at[15:0]}), 64'h0);
        check(dirty && sd == 32'h1111_0007, "R10", "tie snoop dirty data", 64'(sd), 64'h1111_0007);
        check(!mem_seen && cd == 32'h1111_0007, "R10", "cpu hit after snoop", 64'(cd), 64'h1111_0007);
    endtask

    task automatic t_snoop_waits;
        bit early, cpu_got, snp_after, dirty;
        logic [DW-1:0] cd;
        do_snoop(1, 0, '0, "R9"); // Shared -> Invalid
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        check(!cpu_req_ready, "R12", "cpu ready low while busy", 64'(cpu_req_ready), 64'd0);
        while (!mem_req_valid) @(negedge clk);
        check(mem_req_kind == 2'd0, "R11", "load miss kind", 64'(mem_req_kind), 64'd0);
        @(negedge clk);
        snp_valid = 1'b1; snp_kind = 1'b1;
        check(snp_ready, "R11", "snoop accepted while cpu waits", 64'(snp_ready), 64'd1);
        @(negedge clk);
        snp_valid = 1'b0;
        early = 0;
        for (int i = 0; i < 4; i++) begin
            if (snp_rsp_valid) early = 1;
            @(negedge clk);
        end
        check(!early, "R11", "no snoop answer while cpu holds line", 64'(early), 64'd0);
        check(!snp_ready, "R12", "snoop ready low while busy", 64'(snp_ready), 64'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h2222_0008; mem_rsp_excl = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        cpu_got = 0; snp_after = 0; dirty = 1; cd = '0;
        for (int i = 0; i < 10; i++) begin
            if (snp_rsp_valid && cpu_got) begin snp_after = 1; dirty = snp_rsp_dirty; end
            if (snp_rsp_valid && !cpu_got) early = 1;
            if (cpu_rsp_valid) begin cpu_got = 1; cd = cpu_rsp_rdata; end
            @(negedge clk);
        end
        check(cpu_got && cd == 32'h2222_0008, "R11", "cpu fill data", 64'(cd), 64'h2222_0008);
        check(snp_after && !early && !dirty, "R11", "snoop answered after cpu",
              64'({early, snp_after, dirty}), 64'b010);
        do_cpu(0, '0, 1, 2'd0, 32'h3333_0009, 0, 32'h3333_0009, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hits_and_stores();
        t_snoops();
        t_tie();
        t_snoop_waits();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule